// File: doc/BRIEF.md
# Completion Queue Poster

This block owns one circular completion ring that lives in host memory. Finished requests arrive on a valid/ready input. Each one carries a command identifier, a 15-bit status code, a 32-bit result, the id of the submission queue the command came from, and that queue's current head. The block packs these into a 16-byte entry. It computes the memory address of the ring slot at the current tail and issues the entry as a single write beat. It then moves the tail forward.

The host finds new entries without reading any count register. Every entry carries a phase bit in the low bit of its status halfword. The block starts the ring with phase 1 and inverts the phase each time the tail wraps, so the host recognises fresh entries by the phase it expects. The host frees slots by writing a new head value. When the slot after the tail is the head slot, the ring is full: further completions wait on the input until the host frees room. After the last write of a back-to-back run, the block pulses an interrupt request, but only if interrupts were enabled when the ring was created.

Top module: `cq_poster`

## Requirements
- R1: A create pulse latches the base address, entry-size shift, interrupt enable and size field. It sets tail and head to 0 and phase to 1. The ring then holds size field + 1 slots. Before the first create, `cpl_ready_o` is low and no write is issued.
- R2: The write address is base + (tail << entry shift), so one entry occupies 2^shift bytes.
- R3: Each posted entry advances the tail by one. When the tail would reach the ring size, it returns to 0 and the phase bit inverts.
- R4: The entry is little-endian on `wr_data_o`: bits [31:0] result, [63:32] zero, [79:64] submission-queue head, [95:80] submission-queue id, [111:96] command id, [127:112] status halfword.
- R5: The status halfword is the 15-bit status code in bits [15:1] and the phase current at posting in bit 0.
- R6: When (tail + 1) mod size equals head, `cpl_ready_o` is low and nothing is posted. A held completion is posted once a head update frees a slot.
- R7: A head update whose value is greater than or equal to the ring size has no effect.
- R8: While `wr_valid_o` is high and `wr_ready_i` is low, the write beat stays valid with a stable address and data, and no new completion is accepted.
- R9: One cycle after a write beat is accepted with no new completion accepted in the same cycle, `irq_o` pulses for one cycle, and only if interrupts were enabled at create. A back-to-back run gives one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| create_i | input | 1 | Create/initialise the ring with the config below |
| size_field_i | input | QIDX_W | Ring size minus one |
| base_addr_i | input | ADDR_W | Ring base address in host memory |
| entry_shift_i | input | 4 | log2 of entry size in bytes |
| irq_en_i | input | 1 | Interrupt enable for this ring |
| head_wr_i | input | 1 | Host head update strobe |
| head_val_i | input | HEAD_W | New head value |
| cpl_valid_i | input | 1 | Completion available |
| cpl_ready_o | output | 1 | Completion accepted this cycle when valid |
| cpl_cid_i | input | 16 | Command identifier |
| cpl_status_i | input | 15 | Status code |
| cpl_result_i | input | 32 | Command-specific result |
| cpl_sqid_i | input | 16 | Originating submission queue id |
| cpl_sqhead_i | input | 16 | That queue's current head |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_data_o | output | 128 | Entry, little-endian |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The hardest state to reach is a full ring with a completion already waiting on the input, followed by a head update that is out of range. The stimulus fills a four-slot ring three times with the head left at zero and then holds a completion valid. It writes a head equal to the size, which must be ignored, and confirms the input stays stalled. Only a legal head write then lets the held entry go out, at the last slot with the old phase. The wrap is driven across two rings of different sizes and entry shifts, so the phase inversion is seen at both slot boundaries.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int ENTRY_W = 128;

  typedef struct packed {
    logic [14:0] status;
    logic        phase;
    logic [15:0] cid;
    logic [15:0] sqid;
    logic [15:0] sqhead;
    logic [31:0] rsvd;
    logic [31:0] result;
  } cq_entry_t;
endpackage

// File: rtl/cq_ring_ptr.sv
module cq_ring_ptr #(
  parameter int QIDX_W = 11,
  parameter int HEAD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              create_i,
  input  logic [QIDX_W-1:0] size_field_i,
  input  logic              head_wr_i,
  input  logic [HEAD_W-1:0] head_val_i,
  input  logic              post_i,
  output logic [QIDX_W-1:0] tail_o,
  output logic              phase_o,
  output logic              full_o,
  output logic              active_o
);
  localparam int CNT_W = QIDX_W + 1;

  logic [CNT_W-1:0]  size_q;
  logic [QIDX_W-1:0] head_q, tail_q;
  logic              phase_q, active_q;
  logic [CNT_W-1:0]  tail_inc;
  logic              wrap;
  logic [QIDX_W-1:0] tail_next;
  logic              head_ok;

  assign tail_inc  = {1'b0, tail_q} + CNT_W'(1);
  assign wrap      = (tail_inc == size_q);
  assign tail_next = wrap ? '0 : tail_inc[QIDX_W-1:0];
  assign head_ok   = 32'(head_val_i) < 32'(size_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q   <= '0;
      head_q   <= '0;
      tail_q   <= '0;
      phase_q  <= 1'b0;
      active_q <= 1'b0;
    end else if (create_i) begin
      size_q   <= {1'b0, size_field_i} + CNT_W'(1);
      head_q   <= '0;
      tail_q   <= '0;
      phase_q  <= 1'b1;
      active_q <= 1'b1;
    end else begin
      if (head_wr_i && active_q && head_ok) head_q <= head_val_i[QIDX_W-1:0];
      if (post_i) begin
        tail_q <= tail_next;
        if (wrap) phase_q <= ~phase_q;
      end
    end
  end

  assign tail_o   = tail_q;
  assign phase_o  = phase_q;
  assign full_o   = active_q && (tail_next == head_q);
  assign active_o = active_q;

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_i && wrap && !create_i) |=> (tail_q == '0) && (phase_q != $past(phase_q)));

  assert_tail_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> ({1'b0, tail_q} < size_q));

  assert_head_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && head_wr_i && !head_ok && !create_i) |=> $stable(head_q));

  assert_no_post_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_i |-> (active_q && !full_o));
endmodule

// File: rtl/cq_entry_build.sv
module cq_entry_build #(
  parameter int ADDR_W = 32,
  parameter int QIDX_W = 11
) (
  input  logic [ADDR_W-1:0]     base_i,
  input  logic [3:0]            shift_i,
  input  logic [QIDX_W-1:0]     tail_i,
  input  logic                  phase_i,
  input  logic [15:0]           cid_i,
  input  logic [14:0]           status_i,
  input  logic [31:0]           result_i,
  input  logic [15:0]           sqid_i,
  input  logic [15:0]           sqhead_i,
  output logic [ADDR_W-1:0]     addr_o,
  output cq_pkg::cq_entry_t     entry_o
);
  assign addr_o = base_i + (ADDR_W'(tail_i) << shift_i);

  always_comb begin
    entry_o        = '0;
    entry_o.status = status_i;
    entry_o.phase  = phase_i;
    entry_o.cid    = cid_i;
    entry_o.sqid   = sqid_i;
    entry_o.sqhead = sqhead_i;
    entry_o.result = result_i;
  end
endmodule

// File: rtl/cq_irq_gen.sv
module cq_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_en_i,
  input  logic wr_done_i,
  input  logic post_i,
  output logic irq_o
);
  // fire only when the run of postings has ended
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_en_i && wr_done_i && !post_i;
  end
endmodule

// File: rtl/cq_poster.sv
module cq_poster #(
  parameter int ADDR_W = 32,
  parameter int QIDX_W = 11,
  parameter int HEAD_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     create_i,
  input  logic [QIDX_W-1:0]        size_field_i,
  input  logic [ADDR_W-1:0]        base_addr_i,
  input  logic [3:0]               entry_shift_i,
  input  logic                     irq_en_i,
  input  logic                     head_wr_i,
  input  logic [HEAD_W-1:0]        head_val_i,
  input  logic                     cpl_valid_i,
  output logic                     cpl_ready_o,
  input  logic [15:0]              cpl_cid_i,
  input  logic [14:0]              cpl_status_i,
  input  logic [31:0]              cpl_result_i,
  input  logic [15:0]              cpl_sqid_i,
  input  logic [15:0]              cpl_sqhead_i,
  output logic                     wr_valid_o,
  input  logic                     wr_ready_i,
  output logic [ADDR_W-1:0]        wr_addr_o,
  output logic [cq_pkg::ENTRY_W-1:0] wr_data_o,
  output logic                     irq_o
);
  logic [ADDR_W-1:0] base_q;
  logic [3:0]        shift_q;
  logic              irq_en_q;

  logic [QIDX_W-1:0] tail;
  logic              phase, full, active, post, wr_done;
  logic [ADDR_W-1:0] nxt_addr;
  cq_pkg::cq_entry_t nxt_entry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      shift_q  <= '0;
      irq_en_q <= 1'b0;
    end else if (create_i) begin
      base_q   <= base_addr_i;
      shift_q  <= entry_shift_i;
      irq_en_q <= irq_en_i;
    end
  end

  assign cpl_ready_o = active && !full && !create_i && (!wr_valid_o || wr_ready_i);
  assign post        = cpl_valid_i && cpl_ready_o;
  assign wr_done     = wr_valid_o && wr_ready_i;

  cq_ring_ptr #(.QIDX_W(QIDX_W), .HEAD_W(HEAD_W)) u_ptr (
    .clk_i, .rst_ni, .create_i, .size_field_i, .head_wr_i, .head_val_i,
    .post_i(post), .tail_o(tail), .phase_o(phase), .full_o(full), .active_o(active)
  );

  cq_entry_build #(.ADDR_W(ADDR_W), .QIDX_W(QIDX_W)) u_build (
    .base_i(base_q), .shift_i(shift_q), .tail_i(tail), .phase_i(phase),
    .cid_i(cpl_cid_i), .status_i(cpl_status_i), .result_i(cpl_result_i),
    .sqid_i(cpl_sqid_i), .sqhead_i(cpl_sqhead_i),
    .addr_o(nxt_addr), .entry_o(nxt_entry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else if (post) begin
      wr_valid_o <= 1'b1;
      wr_addr_o  <= nxt_addr;
      wr_data_o  <= nxt_entry;
    end else if (wr_ready_i) begin
      wr_valid_o <= 1'b0;
    end
  end

  cq_irq_gen u_irq (
    .clk_i, .rst_ni, .irq_en_i(irq_en_q), .wr_done_i(wr_done), .post_i(post), .irq_o
  );

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  assert_irq_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_en_q && $past(wr_valid_o && wr_ready_i));

  assert_irq_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !cpl_ready_o);
endmodule

// File: tb/cq_poster_bench.sv
`timescale 1ns/1ps
module cq_poster_bench;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic create = 0, irq_en = 0, head_wr = 0, cpl_valid = 0, wr_ready = 1;
  logic [10:0] size_field = 0;
  logic [31:0] base = 0;
  logic [3:0]  shift = 0;
  logic [15:0] head_val = 0, cid = 0, sqid = 0, sqhead = 0;
  logic [14:0] sts = 0;
  logic [31:0] res = 0;
  logic        cpl_ready, wr_valid, irq;
  logic [31:0]  wr_addr;
  logic [127:0] wr_data;

  cq_poster u_cq_poster (
    .clk_i(clk), .rst_ni(rst_n), .create_i(create), .size_field_i(size_field),
    .base_addr_i(base), .entry_shift_i(shift), .irq_en_i(irq_en),
    .head_wr_i(head_wr), .head_val_i(head_val), .cpl_valid_i(cpl_valid),
    .cpl_ready_o(cpl_ready), .cpl_cid_i(cid), .cpl_status_i(sts),
    .cpl_result_i(res), .cpl_sqid_i(sqid), .cpl_sqhead_i(sqhead),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  bit done = 0;

  always @(negedge clk) if (irq) irq_cnt++;

  typedef struct packed {
    logic [15:0] head;
    logic [15:0] cid;
    logic [14:0] sts;
    logic [31:0] res;
    logic [31:0] addr;
    logic        ph;
  } vec_t;

  // ring of 4 slots at 0x1000, 16-byte entries; head kept at tail so never full
  localparam vec_t VEC [6] = '{
    '{16'd0, 16'h0101, 15'h0000, 32'hdead_beef, 32'h0000_1000, 1'b1},
    '{16'd1, 16'h0202, 15'h0002, 32'h1234_5678, 32'h0000_1010, 1'b1},
    '{16'd2, 16'h0303, 15'h4001, 32'h0000_0000, 32'h0000_1020, 1'b1},
    '{16'd3, 16'h0404, 15'h7fff, 32'hffff_ffff, 32'h0000_1030, 1'b1},
    '{16'd0, 16'h0505, 15'h0081, 32'h0bad_cafe, 32'h0000_1000, 1'b0},
    '{16'd1, 16'hffff, 15'h1234, 32'h8000_0001, 32'h0000_1010, 1'b0}
  };

  function automatic logic [127:0] exp_entry(logic [14:0] s, logic p, logic [15:0] c,
      logic [15:0] q, logic [15:0] h, logic [31:0] r);
    return {s, p, c, q, h, 32'h0, r};
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_create(logic [10:0] sf, logic [31:0] b, logic [3:0] sh, logic ie);
    @(negedge clk);
    create = 1; size_field = sf; base = b; shift = sh; irq_en = ie;
    @(negedge clk);
    create = 0;
  endtask

  task automatic head_write(logic [15:0] v);
    @(negedge clk);
    head_wr = 1; head_val = v;
    @(negedge clk);
    head_wr = 0;
  endtask

  task automatic drive_cpl(logic [15:0] c, logic [14:0] s, logic [31:0] r,
      logic [15:0] q, logic [15:0] h);
    cpl_valid = 1; cid = c; sts = s; res = r; sqid = q; sqhead = h;
  endtask

  task automatic post(logic [15:0] c, logic [14:0] s, logic [31:0] r, logic [15:0] q,
      logic [15:0] h, logic [31:0] ea, logic ep, logic ei, string tag);
    @(negedge clk);
    drive_cpl(c, s, r, q, h);
    while (!cpl_ready) @(negedge clk);
    @(negedge clk);
    cpl_valid = 0;
    chk({tag, " R2 addr"}, 128'(wr_addr), 128'(ea));
    chk({tag, " R4 R5 entry"}, wr_data, exp_entry(s, ep, c, q, h, r));
    @(negedge clk);
    chk({tag, " R9 irq"}, 128'(irq), 128'(ei));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: nothing happens before the ring exists
    cpl_valid = 1;
    @(negedge clk);
    chk("R1 ready before create", 128'(cpl_ready), 128'(0));
    chk("R1 no write before create", 128'(wr_valid), 128'(0));
    chk("R9 no irq after reset", 128'(irq), 128'(0));
    cpl_valid = 0;

    // table walk: R1 R2 R3 R4 R5 R9
    do_create(11'd3, 32'h1000, 4'd4, 1'b1);
    for (int i = 0; i < 6; i++) begin
      head_write(VEC[i].head);
      post(VEC[i].cid, VEC[i].sts, VEC[i].res, 16'(i + 1), 16'(i * 3),
           VEC[i].addr, VEC[i].ph, 1'b1, $sformatf("vec%0d R3", i));
    end

    // R6 R7: fill ring with head at 0
    do_create(11'd3, 32'h2000, 4'd4, 1'b1);
    for (int i = 0; i < 3; i++)
      post(16'(i), 15'd1, 32'(i), 16'd2, 16'd0, 32'h2000 + 32'(i * 16), 1'b1, 1'b1, "fill R3");
    @(negedge clk);
    drive_cpl(16'h0abc, 15'h0155, 32'hcafe_0001, 16'd7, 16'd9);
    repeat (3) @(negedge clk);
    chk("R6 ready low when full", 128'(cpl_ready), 128'(0));
    chk("R6 no write when full", 128'(wr_valid), 128'(0));
    head_write(16'd4);
    @(negedge clk);
    chk("R7 head==size ignored", 128'(cpl_ready), 128'(0));
    head_write(16'd1);
    @(negedge clk);
    cpl_valid = 0;
    chk("R6 held entry addr", 128'(wr_addr), 128'(32'h2030));
    chk("R6 held entry data", wr_data, exp_entry(15'h0155, 1'b1, 16'h0abc, 16'd7, 16'd9, 32'hcafe_0001));
    @(negedge clk);

    // R9: back-to-back run, single irq; tail 0 phase 0
    head_write(16'd0);
    irq_cnt = 0;
    @(negedge clk);
    drive_cpl(16'h0011, 15'd3, 32'h11, 16'd1, 16'd1);
    @(negedge clk);
    chk("R9 first of run addr", 128'(wr_addr), 128'(32'h2000));
    drive_cpl(16'h0022, 15'd4, 32'h22, 16'd1, 16'd2);
    @(negedge clk);
    cpl_valid = 0;
    chk("R3 R5 second of run", wr_data, exp_entry(15'd4, 1'b0, 16'h0022, 16'd1, 16'd2, 32'h22));
    repeat (3) @(negedge clk);
    chk("R9 one irq per run", 128'(irq_cnt), 128'(1));

    // R8: backpressure, tail 2 head 0
    wr_ready = 0;
    @(negedge clk);
    drive_cpl(16'h0033, 15'd5, 32'h33, 16'd1, 16'd3);
    @(negedge clk);
    drive_cpl(16'h0044, 15'd6, 32'h44, 16'd1, 16'd4);
    repeat (3) @(negedge clk);
    chk("R8 valid held", 128'(wr_valid), 128'(1));
    chk("R8 addr held", 128'(wr_addr), 128'(32'h2020));
    chk("R8 data held", wr_data, exp_entry(15'd5, 1'b0, 16'h0033, 16'd1, 16'd3, 32'h33));
    chk("R8 no accept while stalled", 128'(cpl_ready), 128'(0));
    cpl_valid = 0;
    wr_ready = 1;
    @(negedge clk);
    chk("R8 released", 128'(wr_valid), 128'(0));
    @(negedge clk);

    // R2 R3 R9: 2-slot ring, 32-byte entries, irq disabled
    do_create(11'd1, 32'h8000, 4'd5, 1'b0);
    post(16'h0a, 15'd1, 32'ha, 16'd3, 16'd0, 32'h8000, 1'b1, 1'b0, "small0 R9 off");
    head_write(16'd1);
    post(16'h0b, 15'd2, 32'hb, 16'd3, 16'd1, 32'h8020, 1'b1, 1'b0, "small1 R2 shift");
    head_write(16'd0);
    post(16'h0c, 15'd3, 32'hc, 16'd3, 16'd2, 32'h8000, 1'b0, 1'b0, "small2 R3 wrap");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule